// File: doc/BRIEF.md
# Four-Lane Operand Swizzle and Write-Mask Stage

This is a datapath stage for a vector unit with four 32-bit lanes. Before an operation runs, it rearranges the lanes of up to three source vectors. Each source has its own 8-bit lane selector and its own sign-flip flag. The rearranged sources leave the block in the same cycle, through combinational outputs. The arithmetic unit that consumes them is outside this block.

When the arithmetic unit's result comes back, the stage combines it with the previous destination value. A 4-bit write mask chooses, lane by lane, which value is kept. The combined vector is stored in a destination register, but only on a cycle when the valid strobe is high. Lanes that the mask does not enable keep the old destination contents bit for bit.

Vectors are packed with lane x in the most significant slot. Lane x occupies bits 127:96, lane y bits 95:64, lane z bits 63:32 and lane w bits 31:0.

Top module: `ws_operand_stage`

## Requirements
- R1: For each source, output lane x takes the source lane named by selector bits 7:6. Output lane y uses bits 5:4, lane z bits 3:2 and lane w bits 1:0. A field value of 0, 1, 2 or 3 picks source lane x, y, z or w. Lane x is packed at bits 127:96 and lane w at bits 31:0.
- R2: When a source's negate flag is high, bit 31 of every swizzled lane of that source is inverted. No other bit changes.
- R3: The three sources a, b and c are swizzled and negated independently. Each uses only its own vector, selector and negate flag.
- R4: On a valid cycle, each destination lane whose mask bit is set is loaded with the matching lane of `result_i`. Mask bit 3 controls lane x, bit 2 lane y, bit 1 lane z and bit 0 lane w.
- R5: On a valid cycle, each destination lane whose mask bit is clear is loaded with the matching lane of `old_dst_i`, exactly.
- R6: When `valid_i` is low, `dst_o` does not change at the clock edge.
- R7: While `rst_n` is low, the destination register is cleared to all zeros, and it ignores `valid_i`.
- R8: The swizzled outputs depend only on the current inputs, with no clock delay. The destination value appears on `dst_o` one clock after the valid cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Load strobe for the destination register |
| src_a_i | input | 128 | Source vector a |
| src_b_i | input | 128 | Source vector b |
| src_c_i | input | 128 | Source vector c |
| sel_a_i | input | 8 | Lane selector for source a |
| sel_b_i | input | 8 | Lane selector for source b |
| sel_c_i | input | 8 | Lane selector for source c |
| neg_a_i | input | 1 | Sign flip for source a |
| neg_b_i | input | 1 | Sign flip for source b |
| neg_c_i | input | 1 | Sign flip for source c |
| wmask_i | input | 4 | Per-lane destination write enable |
| result_i | input | 128 | Result vector from the arithmetic unit |
| old_dst_i | input | 128 | Previous destination contents |
| swz_a_o | output | 128 | Swizzled and negated source a |
| swz_b_o | output | 128 | Swizzled and negated source b |
| swz_c_o | output | 128 | Swizzled and negated source c |
| dst_o | output | 128 | Registered merged destination |

## Verification
The only state in the block is the destination register, so any wrong internal state shows up on `dst_o` one clock after the edge that stored it. A swapped mask bit or a wrong lane source appears as a 32-bit slot holding the result word where the old word belongs, or the reverse. A load that should have been skipped appears as `dst_o` changing after a cycle with valid low. A swizzle fault has no state to hide in, so it shows on the `swz_*_o` outputs in the same cycle as the offending selector.

// File: rtl/ws_pkg.sv
package ws_pkg;

   // Position (lsb) of slot `pos` in a packed vector whose slot 0 is on top.
   function automatic int fld_lsb(input int pos, input int slots, input int width);
      return (slots - 1 - pos) * width;
   endfunction

   // True when n is a power of two and at least 2.
   function automatic bit pow2_ok(input int n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/ws_src_swizzle.sv
module ws_src_swizzle #(
   parameter int LANES  = 4,
   parameter int LANE_W = 32,
   localparam int IDX_W = $clog2(LANES),
   localparam int VEC_W = LANES * LANE_W,
   localparam int SEL_W = LANES * IDX_W
) (
   input  logic [VEC_W-1:0] src_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             neg_i,
   output logic [VEC_W-1:0] swz_o
);
   import ws_pkg::*;

   for (genvar o = 0; o < LANES; o++) begin : g_lane
      logic [IDX_W-1:0]  pick;
      logic [LANE_W-1:0] picked;

      assign pick = sel_i[fld_lsb(o, LANES, IDX_W) +: IDX_W];

      // Full LANES:1 mux per output lane.
      always_comb begin
         picked = '0;
         for (int k = 0; k < LANES; k++) begin
            if (pick == IDX_W'(k)) begin
               picked = src_i[fld_lsb(k, LANES, LANE_W) +: LANE_W];
            end
         end
      end

      // Sign flip touches only the top bit of the lane.
      assign swz_o[fld_lsb(o, LANES, LANE_W) +: LANE_W] =
         {picked[LANE_W-1] ^ neg_i, picked[LANE_W-2:0]};
   end

endmodule

// File: rtl/ws_mask_merge.sv
module ws_mask_merge #(
   parameter int LANES  = 4,
   parameter int LANE_W = 32,
   localparam int VEC_W = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [LANES-1:0] mask_i,
   input  logic [VEC_W-1:0] res_i,
   input  logic [VEC_W-1:0] old_i,
   output logic [VEC_W-1:0] dst_o
);
   import ws_pkg::*;

   for (genvar o = 0; o < LANES; o++) begin : g_lane
      localparam int LSB = fld_lsb(o, LANES, LANE_W);
      // Highest mask bit belongs to the top lane.
      localparam int MBIT = LANES - 1 - o;

      logic [LANE_W-1:0] next_lane;
      logic [LANE_W-1:0] lane_q;

      assign next_lane = mask_i[MBIT] ? res_i[LSB +: LANE_W] : old_i[LSB +: LANE_W];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lane_q <= '0;
         end else if (load_i) begin
            lane_q <= next_lane;
         end
      end

      assign dst_o[LSB +: LANE_W] = lane_q;
   end

endmodule

// File: rtl/ws_operand_stage.sv
module ws_operand_stage #(
   parameter int LANES  = 4,
   parameter int LANE_W = 32,
   localparam int IDX_W = $clog2(LANES),
   localparam int VEC_W = LANES * LANE_W,
   localparam int SEL_W = LANES * IDX_W,
   localparam int N_SRC = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid_i,
   input  logic [VEC_W-1:0] src_a_i,
   input  logic [VEC_W-1:0] src_b_i,
   input  logic [VEC_W-1:0] src_c_i,
   input  logic [SEL_W-1:0] sel_a_i,
   input  logic [SEL_W-1:0] sel_b_i,
   input  logic [SEL_W-1:0] sel_c_i,
   input  logic             neg_a_i,
   input  logic             neg_b_i,
   input  logic             neg_c_i,
   input  logic [LANES-1:0] wmask_i,
   input  logic [VEC_W-1:0] result_i,
   input  logic [VEC_W-1:0] old_dst_i,
   output logic [VEC_W-1:0] swz_a_o,
   output logic [VEC_W-1:0] swz_b_o,
   output logic [VEC_W-1:0] swz_c_o,
   output logic [VEC_W-1:0] dst_o
);
   import ws_pkg::*;

   initial begin
      assert (pow2_ok(LANES))
         else $error("LANES must be a power of two >= 2");
      assert (LANE_W >= 2)
         else $error("LANE_W must be at least 2");
   end

   logic [VEC_W-1:0] src_v [N_SRC];
   logic [SEL_W-1:0] sel_v [N_SRC];
   logic             neg_v [N_SRC];
   logic [VEC_W-1:0] swz_v [N_SRC];

   assign src_v[0] = src_a_i;
   assign src_v[1] = src_b_i;
   assign src_v[2] = src_c_i;
   assign sel_v[0] = sel_a_i;
   assign sel_v[1] = sel_b_i;
   assign sel_v[2] = sel_c_i;
   assign neg_v[0] = neg_a_i;
   assign neg_v[1] = neg_b_i;
   assign neg_v[2] = neg_c_i;

   for (genvar s = 0; s < N_SRC; s++) begin : g_src
      ws_src_swizzle #(
         .LANES  (LANES),
         .LANE_W (LANE_W)
      ) u_swz (
         .src_i (src_v[s]),
         .sel_i (sel_v[s]),
         .neg_i (neg_v[s]),
         .swz_o (swz_v[s])
      );
   end

   assign swz_a_o = swz_v[0];
   assign swz_b_o = swz_v[1];
   assign swz_c_o = swz_v[2];

   ws_mask_merge #(
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) u_merge (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (valid_i),
      .mask_i (wmask_i),
      .res_i  (result_i),
      .old_i  (old_dst_i),
      .dst_o  (dst_o)
   );

endmodule

// File: rtl/ws_operand_stage_chk.sv
module ws_operand_stage_chk #(
   parameter int LANES  = 4,
   parameter int LANE_W = 32,
   localparam int IDX_W = $clog2(LANES),
   localparam int VEC_W = LANES * LANE_W,
   localparam int SEL_W = LANES * IDX_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             valid_i,
   input logic [VEC_W-1:0] src_a_i,
   input logic [VEC_W-1:0] src_b_i,
   input logic [VEC_W-1:0] src_c_i,
   input logic [SEL_W-1:0] sel_a_i,
   input logic [SEL_W-1:0] sel_b_i,
   input logic [SEL_W-1:0] sel_c_i,
   input logic             neg_a_i,
   input logic [LANES-1:0] wmask_i,
   input logic [VEC_W-1:0] result_i,
   input logic [VEC_W-1:0] old_dst_i,
   input logic [VEC_W-1:0] swz_a_o,
   input logic [VEC_W-1:0] swz_b_o,
   input logic [VEC_W-1:0] swz_c_o,
   input logic [VEC_W-1:0] dst_o
);
   import ws_pkg::*;

   logic [SEL_W-1:0] ident_sel;
   logic [VEC_W-1:0] sign_bits;

   always_comb begin
      ident_sel = '0;
      sign_bits = '0;
      for (int o = 0; o < LANES; o++) begin
         ident_sel[fld_lsb(o, LANES, IDX_W) +: IDX_W] = IDX_W'(o);
         sign_bits[fld_lsb(o, LANES, LANE_W) + LANE_W - 1] = 1'b1;
      end
   end

   // R1
   ident_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_a_i == ident_sel && !neg_a_i) |-> swz_a_o == src_a_i);

   // R2
   neg_sign_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_a_i == ident_sel) |-> (swz_a_o ^ src_a_i) == (neg_a_i ? sign_bits : '0));

   // R3
   src_b_ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_b_i == ident_sel) |-> (((swz_b_o ^ src_b_i) & ~sign_bits) == '0));

   // R3
   src_c_ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_c_i == ident_sel) |-> (((swz_c_o ^ src_c_i) & ~sign_bits) == '0));

   // R4
   full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && wmask_i == '1) |=> dst_o == $past(result_i));

   // R5
   empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && wmask_i == '0) |=> dst_o == $past(old_dst_i));

   // R6
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> $stable(dst_o));

   // R7
   rst_clear_chk: assert property (@(posedge clk)
      !rst_n |=> dst_o == '0);

endmodule

bind ws_operand_stage ws_operand_stage_chk #(
   .LANES  (LANES),
   .LANE_W (LANE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .valid_i   (valid_i),
   .src_a_i   (src_a_i),
   .src_b_i   (src_b_i),
   .src_c_i   (src_c_i),
   .sel_a_i   (sel_a_i),
   .sel_b_i   (sel_b_i),
   .sel_c_i   (sel_c_i),
   .neg_a_i   (neg_a_i),
   .wmask_i   (wmask_i),
   .result_i  (result_i),
   .old_dst_i (old_dst_i),
   .swz_a_o   (swz_a_o),
   .swz_b_o   (swz_b_o),
   .swz_c_o   (swz_c_o),
   .dst_o     (dst_o)
);

// File: tb/test_ws_operand_stage.sv
module test_ws_operand_stage;
   localparam int CLK_P = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         valid_i = 1'b0;
   logic [127:0] src_a_i = '0, src_b_i = '0, src_c_i = '0;
   logic [7:0]   sel_a_i = '0, sel_b_i = '0, sel_c_i = '0;
   logic         neg_a_i = 1'b0, neg_b_i = 1'b0, neg_c_i = 1'b0;
   logic [3:0]   wmask_i = '0;
   logic [127:0] result_i = '0, old_dst_i = '0;
   logic [127:0] swz_a_o, swz_b_o, swz_c_o, dst_o;

   int checks = 0;
   int failures = 0;
   logic [127:0] exp_dst = '0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   ws_operand_stage i_ws_operand_stage (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i),
      .src_a_i(src_a_i), .src_b_i(src_b_i), .src_c_i(src_c_i),
      .sel_a_i(sel_a_i), .sel_b_i(sel_b_i), .sel_c_i(sel_c_i),
      .neg_a_i(neg_a_i), .neg_b_i(neg_b_i), .neg_c_i(neg_c_i),
      .wmask_i(wmask_i), .result_i(result_i), .old_dst_i(old_dst_i),
      .swz_a_o(swz_a_o), .swz_b_o(swz_b_o), .swz_c_o(swz_c_o), .dst_o(dst_o)
   );

   // Reference: field for output lane i sits at 7-2i..6-2i; lane k at 127-32k.
   function automatic logic [127:0] ref_swz(input logic [127:0] s, input logic [7:0] sel,
                                            input logic n);
      logic [127:0] r = '0;
      for (int i = 0; i < 4; i++) begin
         int k;
         logic [31:0] v;
         k = int'((sel >> (6 - 2*i)) & 8'd3);
         v = 32'(s >> (96 - 32*k));
         v[31] = v[31] ^ n;
         r = r | ({96'b0, v} << (96 - 32*i));
      end
      return r;
   endfunction

   function automatic logic [127:0] ref_merge(input logic [3:0] m, input logic [127:0] res,
                                              input logic [127:0] old);
      logic [127:0] r = '0;
      for (int i = 0; i < 4; i++) begin
         logic [31:0] v;
         v = m[3-i] ? 32'(res >> (96 - 32*i)) : 32'(old >> (96 - 32*i));
         r = r | ({96'b0, v} << (96 - 32*i));
      end
      return r;
   endfunction

   function automatic logic [127:0] rnd128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_swz();
      #1;
      chk("R1/R2/R8 src a", swz_a_o, ref_swz(src_a_i, sel_a_i, neg_a_i));
      chk("R3 src b", swz_b_o, ref_swz(src_b_i, sel_b_i, neg_b_i));
      chk("R3 src c", swz_c_o, ref_swz(src_c_i, sel_c_i, neg_c_i));
   endtask

   // Inputs already applied after a negedge: clock once and compare.
   task automatic step(input string req);
      check_swz();
      @(posedge clk);
      if (!rst_n) exp_dst = '0;
      else if (valid_i) exp_dst = ref_merge(wmask_i, result_i, old_dst_i);
      @(negedge clk);
      chk(req, dst_o, exp_dst);
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R7: reset clears, valid ignored during reset
      valid_i = 1'b1; wmask_i = 4'hF; result_i = rnd128();
      @(negedge clk);
      step("R7 reset value");
      step("R7 valid ignored in reset");
      rst_n = 1'b1;

      // R1 R2 R3 R4 R5: every selector on each source, every mask
      for (int s = 0; s < 256; s++) begin
         src_a_i = rnd128(); src_b_i = rnd128(); src_c_i = rnd128();
         sel_a_i = 8'(s); sel_b_i = ~8'(s); sel_c_i = 8'(s * 37 + 11);
         neg_a_i = s[0]; neg_b_i = s[1]; neg_c_i = s[2];
         result_i = rnd128(); old_dst_i = rnd128();
         wmask_i = 4'(s); valid_i = 1'b1;
         step("R4/R5 merge");
      end

      // R4 R5: masks with distinctive words
      for (int m = 0; m < 16; m++) begin
         result_i = {4{32'h8000_0001}} ^ {32'h1, 32'h2, 32'h3, 32'h4};
         old_dst_i = {4{32'h7FFF_FFFE}} ^ {32'h10, 32'h20, 32'h30, 32'h40};
         wmask_i = 4'(m); valid_i = 1'b1;
         step("R4/R5 mask sweep");
      end

      // R6: valid low holds the destination
      for (int i = 0; i < 20; i++) begin
         valid_i = 1'b0; wmask_i = 4'($urandom);
         result_i = rnd128(); old_dst_i = rnd128();
         step("R6 hold on idle");
      end

      // R2: sign flip on sign-heavy values
      src_a_i = {32'hFFFF_FFFF, 32'h0, 32'h8000_0000, 32'h7FFF_FFFF};
      sel_a_i = 8'h1B; neg_a_i = 1'b1; valid_i = 1'b0;
      step("R2 sign only");
      sel_a_i = 8'hE4; neg_a_i = 1'b0;
      step("R1 reverse order");

      // R7: reset mid-run
      valid_i = 1'b1; wmask_i = 4'hF; result_i = rnd128();
      step("R4 before reset");
      rst_n = 1'b0;
      #1;
      chk("R7 async clear", dst_o, '0);
      exp_dst = '0;
      step("R7 held in reset");
      rst_n = 1'b1;
      step("R4 after reset");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule